// File: doc/BRIEF.md
# Floating-Point Fault Pointer Capture

This block keeps a record of the floating-point instruction decoded most recently. When an arithmetic error surfaces later, the integer pipeline may already have moved on, and an error handler still needs to know which instruction faulted. On each qualifying decode the block records four things: the code selector and offset of the instruction, counting its first prefix byte; an 11-bit opcode; and, if the instruction has a memory operand, the data selector and offset.

Software copies the record out with a save sequence and writes it back with a restore sequence. Both sequences move four words over a valid/ready stream. The word layout depends on two inputs. Operating mode picks protected or real addressing, and virtual-8086 mode counts as real. The code segment default-size bit picks 32-bit or 16-bit words. The block latches the layout when a transfer starts. A restore takes effect as one update after its last word arrives.

Top module: `fpptr_unit`

## Requirements
- R1: A decode with `dec_valid`=1 and `dec_ctrl`=0, accepted while `busy`=0, stores `dec_cs_sel` and `dec_ip_off` as the instruction pointer. It stores the opcode as {`dec_opc_low`[2:0], `dec_modrm`[7:0]}, with the modrm byte in bits 7:0. The result is visible from the next cycle.
- R2: Such a decode stores `dec_ds_sel` and `dec_dp_off` as the data pointer only when `dec_has_mem`=1. Otherwise the data pointer keeps its previous value.
- R3: A decode with `dec_ctrl`=1 changes no stored field.
- R4: Layout selection: protected layouts apply when `mode_prot`=1 and `mode_v86`=0; every other combination uses the real layouts. `cs_d32`=1 selects 32-bit words. The layout is latched on the cycle a transfer starts, and later changes to the mode inputs do not affect that transfer.
- R5: The 32-bit protected save image is, in word order: ip offset; {5'b0, opcode[10:0], cs selector[15:0]}; dp offset; {16'b0, ds selector}.
- R6: The 16-bit protected save image is ip offset[15:0], cs selector, dp offset[15:0], ds selector. Each word is zero-extended to 32 bits, and the opcode is left out.
- R7: In the real layouts, each linear address is (selector*16 + offset[19:0]) mod 2^20. The words are L_ip[15:0]; {L_ip[19:16], 1'b0, opcode}; L_dp[15:0]; {L_dp[19:16], 12'b0}. Each word is zero-extended in bits 31:16, in both sizes.
- R8: A save begins the cycle after `save_start` is accepted. It presents four words on `sv_valid`/`sv_data` and advances one word per cycle in which `sv_ready`=1. The data holds steady while stalled, and `sv_last` marks the fourth word.
- R9: A restore begins the cycle after `rest_start` is accepted. With `rs_ready`=1 it takes four words, one per cycle with `rs_valid`=1, in the save order. It updates all stored fields together on the cycle of the fourth word. Protected 32-bit restore reads the opcode from word 1 bits 26:16. Protected 16-bit restore uses only bits 15:0 of each word, zero-extends the offsets and keeps the opcode. Real restore clears both selectors, sets each offset to its 20-bit linear address, takes the opcode from word 1 bits 10:0, and ignores bits 31:16 and word 1 bit 11.
- R10: While `busy`=1, decodes, `save_start` and `rest_start` are ignored. If `save_start` and `rest_start` arrive together, the save runs and the restore is dropped.
- R11: After reset, `busy`, `sv_valid` and `rs_ready` are 0 and every stored field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A floating-point instruction was decoded this cycle |
| dec_ctrl | input | 1 | Decoded instruction only saves or restores state |
| dec_has_mem | input | 1 | Decoded instruction has a memory operand |
| dec_cs_sel | input | 16 | Code selector of the instruction |
| dec_ip_off | input | 32 | Offset of the instruction, counting its first prefix |
| dec_ds_sel | input | 16 | Selector of the memory operand |
| dec_dp_off | input | 32 | Offset of the memory operand |
| dec_opc_low | input | 3 | Low three bits of the first opcode byte |
| dec_modrm | input | 8 | ModR/M byte |
| mode_prot | input | 1 | Protected mode active |
| mode_v86 | input | 1 | Virtual-8086 mode active |
| cs_d32 | input | 1 | Code segment default size is 32 bits |
| save_start | input | 1 | Request a save sequence |
| sv_ready | input | 1 | Consumer accepts the current save word |
| sv_valid | output | 1 | Save word present |
| sv_data | output | 32 | Save word |
| sv_last | output | 1 | Current save word is the fourth |
| rest_start | input | 1 | Request a restore sequence |
| rs_valid | input | 1 | Restore word present |
| rs_data | input | 32 | Restore word |
| rs_ready | output | 1 | Block accepts restore words |
| busy | output | 1 | A save or restore is in progress |

## Verification
A decode registers on the rising edge where `dec_valid` is sampled, so the next save already reflects it. The first save word appears one cycle after the edge that accepts `save_start`, and each later word follows the handshake edge where `sv_ready` is high. A restore commits on the edge that takes its fourth word, and any save requested afterwards shows the new contents. The bench drives inputs on the falling edge and samples outputs 2 ns after it. Each expected save word goes into a queue when the request is made and is compared as the handshake completes, so stalls and out-of-turn requests move only the cycle of the comparison and never the expected value.

// File: rtl/fpptr_pkg.sv
package fpptr_pkg;

    localparam int SEL_W     = 16;
    localparam int OFF_W     = 32;
    localparam int OPC_W     = 11;
    localparam int LIN_W     = 20;
    localparam int IMG_W     = 32;
    localparam int IMG_WORDS = 4;
    localparam int IDX_W     = $clog2(IMG_WORDS);
    localparam int HALF_W    = IMG_W / 2;

    typedef enum logic [1:0] {
        FMT_P32 = 2'd0,
        FMT_P16 = 2'd1,
        FMT_R32 = 2'd2,
        FMT_R16 = 2'd3
    } img_fmt_e;

    typedef struct packed {
        logic [SEL_W-1:0] ip_sel;
        logic [OFF_W-1:0] ip_off;
        logic [SEL_W-1:0] dp_sel;
        logic [OFF_W-1:0] dp_off;
        logic [OPC_W-1:0] opc;
    } ptr_set_t;

    typedef logic [IMG_WORDS-1:0][IMG_W-1:0] img_blk_t;

    function automatic img_fmt_e pick_fmt(input logic prot, input logic v86, input logic d32);
        if (prot && !v86) return d32 ? FMT_P32 : FMT_P16;
        return d32 ? FMT_R32 : FMT_R16;
    endfunction

    function automatic logic [LIN_W-1:0] to_linear(input logic [SEL_W-1:0] sel,
                                                   input logic [OFF_W-1:0] off);
        logic [LIN_W-1:0] base;
        base = {sel, 4'h0};
        return base + off[LIN_W-1:0];
    endfunction

    function automatic logic [IMG_W-1:0] image_word(input img_fmt_e fmt,
                                                    input logic [IDX_W-1:0] idx,
                                                    input ptr_set_t p);
        logic [LIN_W-1:0] il;
        logic [LIN_W-1:0] dl;
        logic [IMG_W-1:0] w;
        il = to_linear(p.ip_sel, p.ip_off);
        dl = to_linear(p.dp_sel, p.dp_off);
        w  = '0;
        unique case (fmt)
            FMT_P32: begin
                case (idx)
                    IDX_W'(0): w = p.ip_off;
                    IDX_W'(1): w = {5'b0, p.opc, p.ip_sel};
                    IDX_W'(2): w = p.dp_off;
                    default:   w = {{HALF_W{1'b0}}, p.dp_sel};
                endcase
            end
            FMT_P16: begin
                case (idx)
                    IDX_W'(0): w = {{HALF_W{1'b0}}, p.ip_off[HALF_W-1:0]};
                    IDX_W'(1): w = {{HALF_W{1'b0}}, p.ip_sel};
                    IDX_W'(2): w = {{HALF_W{1'b0}}, p.dp_off[HALF_W-1:0]};
                    default:   w = {{HALF_W{1'b0}}, p.dp_sel};
                endcase
            end
            default: begin
                case (idx)
                    IDX_W'(0): w = {{HALF_W{1'b0}}, il[15:0]};
                    IDX_W'(1): w = {{HALF_W{1'b0}}, il[19:16], 1'b0, p.opc};
                    IDX_W'(2): w = {{HALF_W{1'b0}}, dl[15:0]};
                    default:   w = {{HALF_W{1'b0}}, dl[19:16], 12'h000};
                endcase
            end
        endcase
        return w;
    endfunction

    function automatic ptr_set_t parse_image(input img_fmt_e fmt,
                                             input img_blk_t blk,
                                             input ptr_set_t old);
        ptr_set_t r;
        r = old;
        unique case (fmt)
            FMT_P32: begin
                r.ip_off = blk[0];
                r.opc    = blk[1][26:16];
                r.ip_sel = blk[1][15:0];
                r.dp_off = blk[2];
                r.dp_sel = blk[3][15:0];
            end
            FMT_P16: begin
                r.ip_off = {{(OFF_W-HALF_W){1'b0}}, blk[0][15:0]};
                r.ip_sel = blk[1][15:0];
                r.dp_off = {{(OFF_W-HALF_W){1'b0}}, blk[2][15:0]};
                r.dp_sel = blk[3][15:0];
            end
            default: begin
                r.ip_sel = '0;
                r.ip_off = {{(OFF_W-LIN_W){1'b0}}, blk[1][15:12], blk[0][15:0]};
                r.opc    = blk[1][10:0];
                r.dp_sel = '0;
                r.dp_off = {{(OFF_W-LIN_W){1'b0}}, blk[3][15:12], blk[2][15:0]};
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpptr_store.sv
module fpptr_store
    import fpptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             cap_mem,
    input  logic [SEL_W-1:0] cap_ip_sel,
    input  logic [OFF_W-1:0] cap_ip_off,
    input  logic [SEL_W-1:0] cap_dp_sel,
    input  logic [OFF_W-1:0] cap_dp_off,
    input  logic [OPC_W-1:0] cap_opc,
    input  logic             ld_en,
    input  ptr_set_t         ld_val,
    output ptr_set_t         ptrs
);

    ptr_set_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (ld_en) begin
            cur_q <= ld_val;
        end else if (cap_en) begin
            cur_q.ip_sel <= cap_ip_sel;
            cur_q.ip_off <= cap_ip_off;
            cur_q.opc    <= cap_opc;
            if (cap_mem) begin
                cur_q.dp_sel <= cap_dp_sel;
                cur_q.dp_off <= cap_dp_off;
            end
        end
    end

    assign ptrs = cur_q;

endmodule

// File: rtl/fpptr_save_seq.sv
module fpptr_save_seq
    import fpptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  img_fmt_e         fmt_in,
    input  ptr_set_t         ptrs,
    input  logic             sv_ready,
    output logic             sv_valid,
    output logic [IMG_W-1:0] sv_data,
    output logic             sv_last,
    output logic             active
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);

    img_fmt_e         fmt_q;
    logic [IDX_W-1:0] idx_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            idx_q <= '0;
            fmt_q <= FMT_P32;
        end else if (!act_q) begin
            if (start) begin
                act_q <= 1'b1;
                idx_q <= '0;
                fmt_q <= fmt_in;
            end
        end else if (sv_ready) begin
            if (idx_q == LAST_IDX) act_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign sv_valid = act_q;
    assign sv_data  = act_q ? image_word(fmt_q, idx_q, ptrs) : '0;
    assign sv_last  = act_q && (idx_q == LAST_IDX);
    assign active   = act_q;

endmodule

// File: rtl/fpptr_rest_seq.sv
module fpptr_rest_seq
    import fpptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  img_fmt_e         fmt_in,
    input  logic             rs_valid,
    input  logic [IMG_W-1:0] rs_data,
    input  ptr_set_t         old_ptrs,
    output logic             rs_ready,
    output logic             ld_en,
    output ptr_set_t         ld_val,
    output logic             active
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_WORDS - 1);

    img_fmt_e         fmt_q;
    logic [IDX_W-1:0] idx_q;
    logic             act_q;
    logic             take;
    img_blk_t         blk_n;

    assign take = act_q && rs_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            idx_q <= '0;
            fmt_q <= FMT_P32;
        end else if (!act_q) begin
            if (start) begin
                act_q <= 1'b1;
                idx_q <= '0;
                fmt_q <= fmt_in;
            end
        end else if (take) begin
            if (idx_q == LAST_IDX) act_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < IMG_WORDS; g++) begin : g_word
        if (g == IMG_WORDS - 1) begin : g_tail
            assign blk_n[g] = rs_data;
        end else begin : g_body
            logic [IMG_W-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (rst) slot_q <= '0;
                else if (take && idx_q == IDX_W'(g)) slot_q <= rs_data;
            end
            assign blk_n[g] = slot_q;
        end
    end

    assign rs_ready = act_q;
    assign ld_en    = take && (idx_q == LAST_IDX);
    assign ld_val   = parse_image(fmt_q, blk_n, old_ptrs);
    assign active   = act_q;

endmodule

// File: rtl/fpptr_unit.sv
module fpptr_unit
    import fpptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic             dec_ctrl,
    input  logic             dec_has_mem,
    input  logic [SEL_W-1:0] dec_cs_sel,
    input  logic [OFF_W-1:0] dec_ip_off,
    input  logic [SEL_W-1:0] dec_ds_sel,
    input  logic [OFF_W-1:0] dec_dp_off,
    input  logic [2:0]       dec_opc_low,
    input  logic [7:0]       dec_modrm,
    input  logic             mode_prot,
    input  logic             mode_v86,
    input  logic             cs_d32,
    input  logic             save_start,
    input  logic             sv_ready,
    output logic             sv_valid,
    output logic [IMG_W-1:0] sv_data,
    output logic             sv_last,
    input  logic             rest_start,
    input  logic             rs_valid,
    input  logic [IMG_W-1:0] rs_data,
    output logic             rs_ready,
    output logic             busy
);

    logic     save_act;
    logic     rest_act;
    logic     save_go;
    logic     rest_go;
    logic     cap_en;
    logic     ld_en;
    ptr_set_t ld_val;
    ptr_set_t ptr_q;
    img_fmt_e cur_fmt;

    assign busy    = save_act || rest_act;
    assign save_go = save_start && !busy;
    assign rest_go = rest_start && !busy && !save_start;
    assign cap_en  = dec_valid && !dec_ctrl && !busy;
    assign cur_fmt = pick_fmt(mode_prot, mode_v86, cs_d32);

    fpptr_store u_store (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (cap_en),
        .cap_mem    (dec_has_mem),
        .cap_ip_sel (dec_cs_sel),
        .cap_ip_off (dec_ip_off),
        .cap_dp_sel (dec_ds_sel),
        .cap_dp_off (dec_dp_off),
        .cap_opc    ({dec_opc_low, dec_modrm}),
        .ld_en      (ld_en),
        .ld_val     (ld_val),
        .ptrs       (ptr_q)
    );

    fpptr_save_seq u_save (
        .clk      (clk),
        .rst      (rst),
        .start    (save_go),
        .fmt_in   (cur_fmt),
        .ptrs     (ptr_q),
        .sv_ready (sv_ready),
        .sv_valid (sv_valid),
        .sv_data  (sv_data),
        .sv_last  (sv_last),
        .active   (save_act)
    );

    fpptr_rest_seq u_rest (
        .clk      (clk),
        .rst      (rst),
        .start    (rest_go),
        .fmt_in   (cur_fmt),
        .rs_valid (rs_valid),
        .rs_data  (rs_data),
        .old_ptrs (ptr_q),
        .rs_ready (rs_ready),
        .ld_en    (ld_en),
        .ld_val   (ld_val),
        .active   (rest_act)
    );

endmodule

// File: rtl/fpptr_unit_chk.sv
module fpptr_unit_chk
    import fpptr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             sv_valid,
    input logic             sv_ready,
    input logic [IMG_W-1:0] sv_data,
    input logic             sv_last,
    input logic             rs_ready,
    input logic             dec_valid,
    input logic             dec_ctrl,
    input logic             dec_has_mem,
    input logic [OFF_W-1:0] dec_ip_off,
    input ptr_set_t         ptr_q
);

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        sv_valid && !sv_ready |=> sv_valid && $stable(sv_data) && $stable(sv_last));

    a_r8_last_valid: assert property (@(posedge clk) disable iff (rst)
        sv_last |-> sv_valid);

    a_r10_one_transfer: assert property (@(posedge clk) disable iff (rst)
        !(sv_valid && rs_ready));

    a_r10_busy_covers: assert property (@(posedge clk) disable iff (rst)
        (sv_valid || rs_ready) |-> busy);

    a_r10_save_freeze: assert property (@(posedge clk) disable iff (rst)
        sv_valid |=> $stable(ptr_q));

    a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        dec_valid && dec_ctrl && !busy |=> $stable(ptr_q));

    a_r2_dp_hold: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_has_mem && !busy |=> $stable(ptr_q.dp_sel) && $stable(ptr_q.dp_off));

    a_r1_ip_capture: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ctrl && !busy |=> ptr_q.ip_off == $past(dec_ip_off));

    a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !sv_valid && !rs_ready);

endmodule

bind fpptr_unit fpptr_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .sv_valid    (sv_valid),
    .sv_ready    (sv_ready),
    .sv_data     (sv_data),
    .sv_last     (sv_last),
    .rs_ready    (rs_ready),
    .dec_valid   (dec_valid),
    .dec_ctrl    (dec_ctrl),
    .dec_has_mem (dec_has_mem),
    .dec_ip_off  (dec_ip_off),
    .ptr_q       (ptr_q)
);

// File: tb/fpptr_unit_test.sv
`timescale 1ns/1ps
module fpptr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 0, dec_ctrl = 0, dec_has_mem = 0;
    logic [15:0] dec_cs_sel = 0, dec_ds_sel = 0;
    logic [31:0] dec_ip_off = 0, dec_dp_off = 0;
    logic [2:0]  dec_opc_low = 0;
    logic [7:0]  dec_modrm = 0;
    logic        mode_prot = 0, mode_v86 = 0, cs_d32 = 0;
    logic        save_start = 0, sv_ready = 0, rest_start = 0, rs_valid = 0;
    logic [31:0] rs_data = 0;
    logic        sv_valid, sv_last, rs_ready, busy;
    logic [31:0] sv_data;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ip_sel = 0, m_dp_sel = 0;
    logic [31:0] m_ip_off = 0, m_dp_off = 0;
    logic [10:0] m_opc = 0;

    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    fpptr_unit uut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_ctrl(dec_ctrl), .dec_has_mem(dec_has_mem),
        .dec_cs_sel(dec_cs_sel), .dec_ip_off(dec_ip_off),
        .dec_ds_sel(dec_ds_sel), .dec_dp_off(dec_dp_off),
        .dec_opc_low(dec_opc_low), .dec_modrm(dec_modrm),
        .mode_prot(mode_prot), .mode_v86(mode_v86), .cs_d32(cs_d32),
        .save_start(save_start), .sv_ready(sv_ready), .sv_valid(sv_valid),
        .sv_data(sv_data), .sv_last(sv_last),
        .rest_start(rest_start), .rs_valid(rs_valid), .rs_data(rs_data),
        .rs_ready(rs_ready), .busy(busy)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] lin(input logic [15:0] s, input logic [31:0] o);
        int t;
        t = int'(s) * 16 + int'(o[19:0]);
        return t[19:0];
    endfunction

    function automatic logic [31:0] ew(input bit prot, input bit v86, input bit d32, input int i);
        logic [19:0] a;
        logic [19:0] b;
        a = lin(m_ip_sel, m_ip_off);
        b = lin(m_dp_sel, m_dp_off);
        if (prot && !v86 && d32) begin
            if (i == 0) return m_ip_off;
            if (i == 1) return (32'(m_opc) << 16) | 32'(m_ip_sel);
            if (i == 2) return m_dp_off;
            return 32'(m_dp_sel);
        end
        if (prot && !v86) begin
            if (i == 0) return 32'(m_ip_off[15:0]);
            if (i == 1) return 32'(m_ip_sel);
            if (i == 2) return 32'(m_dp_off[15:0]);
            return 32'(m_dp_sel);
        end
        if (i == 0) return 32'(a[15:0]);
        if (i == 1) return (32'(a[19:16]) << 12) | 32'(m_opc);
        if (i == 2) return 32'(b[15:0]);
        return 32'(b[19:16]) << 12;
    endfunction

    // Monitor: compares each accepted save word with the queued expectation (R5-R8)
    initial forever begin
        @(negedge clk);
        #2;
        if (sv_valid && sv_ready) begin
            if (exp_q.size() == 0) begin
                chk("R8", "unexpected save word", {31'b0, sv_last, sv_data}, 64'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "save word {last,data}", {31'b0, sv_last, sv_data}, {31'b0, e});
            end
        end
    end

    task automatic set_mode(input bit prot, input bit v86, input bit d32);
        mode_prot = prot; mode_v86 = v86; cs_d32 = d32;
    endtask

    task automatic decode(input bit ctrl, input bit mem, input logic [15:0] cs, input logic [31:0] ip,
                          input logic [15:0] ds, input logic [31:0] dp, input logic [2:0] ol,
                          input logic [7:0] mr, input bit expect_cap);
        @(negedge clk);
        dec_valid = 1; dec_ctrl = ctrl; dec_has_mem = mem;
        dec_cs_sel = cs; dec_ip_off = ip; dec_ds_sel = ds; dec_dp_off = dp;
        dec_opc_low = ol; dec_modrm = mr;
        @(negedge clk);
        dec_valid = 0;
        if (expect_cap && !ctrl) begin
            m_ip_sel = cs; m_ip_off = ip; m_opc = {ol, mr};
            if (mem) begin m_dp_sel = ds; m_dp_off = dp; end
        end
    endtask

    task automatic save_begin(input bit prot, input bit v86, input bit d32, input string tag);
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back({(i == 3) ? 1'b1 : 1'b0, ew(prot, v86, d32, i)});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        set_mode(prot, v86, d32);
        save_start = 1; sv_ready = 0;
        @(negedge clk);
        save_start = 0;
    endtask

    task automatic save_finish();
        sv_ready = 1;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        sv_ready = 0;
    endtask

    task automatic do_save(input bit prot, input bit v86, input bit d32, input int stall, input string tag);
        save_begin(prot, v86, d32, tag);
        repeat (stall) @(negedge clk);
        save_finish();
    endtask

    task automatic do_restore(input bit prot, input bit v86, input bit d32,
                              input logic [31:0] w0, input logic [31:0] w1,
                              input logic [31:0] w2, input logic [31:0] w3, input bit gap);
        logic [31:0] w[4];
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        @(negedge clk);
        set_mode(prot, v86, d32);
        rest_start = 1;
        @(negedge clk);
        rest_start = 0;
        chk("R9", "rs_ready after start", 64'(rs_ready), 64'h1);
        for (int i = 0; i < 4; i++) begin
            rs_data = w[i]; rs_valid = 1;
            @(negedge clk);
            if (gap && i == 1) begin
                rs_valid = 0;
                @(negedge clk);
            end
        end
        rs_valid = 0;
        chk("R9", "rs_ready after last word", 64'(rs_ready), 64'h0);
        if (prot && !v86 && d32) begin
            m_ip_off = w0; m_opc = w1[26:16]; m_ip_sel = w1[15:0];
            m_dp_off = w2; m_dp_sel = w3[15:0];
        end else if (prot && !v86) begin
            m_ip_off = {16'h0, w0[15:0]}; m_ip_sel = w1[15:0];
            m_dp_off = {16'h0, w2[15:0]}; m_dp_sel = w3[15:0];
        end else begin
            m_ip_sel = 0; m_ip_off = {12'h0, w1[15:12], w0[15:0]}; m_opc = w1[10:0];
            m_dp_sel = 0; m_dp_off = {12'h0, w3[15:12], w2[15:0]};
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: idle and cleared after reset
        chk("R11", "busy", 64'(busy), 64'h0);
        chk("R11", "sv_valid", 64'(sv_valid), 64'h0);
        chk("R11", "rs_ready", 64'(rs_ready), 64'h0);
        do_save(1, 0, 1, 0, "R11");

        // R1 R2: capture with memory operand, read out in every layout (R4 R5 R6 R7)
        decode(0, 1, 16'h1234, 32'h89AB_CDEF, 16'h5678, 32'h0BAD_F00D, 3'd5, 8'hC3, 1);
        do_save(1, 0, 1, 0, "R5");
        do_save(1, 0, 0, 1, "R6");
        do_save(1, 1, 0, 0, "R4");
        do_save(0, 0, 1, 2, "R7");

        // R2: no memory operand leaves the data pointer
        decode(0, 0, 16'h4321, 32'h0000_1111, 16'hDEAD, 32'hBEEF_0000, 3'd2, 8'h17, 1);
        do_save(1, 0, 1, 0, "R2");

        // R3: control decode changes nothing
        decode(1, 1, 16'h7777, 32'h7777_7777, 16'h7777, 32'h7777_7777, 3'd7, 8'h77, 0);
        do_save(1, 0, 1, 0, "R3");

        // R7: linear address wraps at 20 bits
        decode(0, 1, 16'hFFFF, 32'h0000_FFFF, 16'hF000, 32'h0001_2345, 3'd1, 8'h9A, 1);
        do_save(0, 0, 0, 0, "R7");

        // R4 R8 R10: stalled save, mode change, decode and restore request while busy
        save_begin(1, 0, 1, "R4");
        set_mode(0, 0, 0);
        decode(0, 1, 16'h0101, 32'h0202_0202, 16'h0303, 32'h0404_0404, 3'd3, 8'h55, 0);
        rest_start = 1;
        @(negedge clk);
        rest_start = 0;
        chk("R10", "busy during stalled save", 64'(busy), 64'h1);
        save_finish();
        chk("R10", "restore request dropped", 64'(rs_ready), 64'h0);
        do_save(1, 0, 1, 0, "R10");

        // R10: simultaneous requests, save wins
        @(negedge clk);
        set_mode(1, 0, 1);
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back({(i == 3) ? 1'b1 : 1'b0, ew(1, 0, 1, i)});
            tag_q.push_back("R10");
        end
        save_start = 1; rest_start = 1; sv_ready = 0;
        @(negedge clk);
        save_start = 0; rest_start = 0;
        chk("R10", "save active on tie", 64'(sv_valid), 64'h1);
        chk("R10", "restore idle on tie", 64'(rs_ready), 64'h0);
        save_finish();

        // R9: restore in each layout, read back
        do_restore(1, 0, 1, 32'h0040_1000, 32'h05A5_0008, 32'h0000_2000, 32'h0000_0010, 0);
        do_save(1, 0, 1, 0, "R9");
        do_restore(1, 0, 0, 32'hAAAA_1111, 32'h0000_2222, 32'h0000_3333, 32'h0000_4444, 1);
        do_save(1, 0, 1, 0, "R9");
        do_restore(0, 0, 1, 32'hFFFF_5555, 32'h1234_AFFF, 32'h0000_6666, 32'h0000_B000, 0);
        do_save(1, 0, 1, 0, "R9");
        do_save(1, 1, 1, 1, "R9");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule